// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block turns a parallel word into a serial bit stream. A chain of stages captures a whole word while an active-low load line is held low. Once the load line is released, each rising edge of a combined shift clock moves the contents one stage toward the output end. A serial input fills the first stage on every shift. The last stage drives two outputs, one true and one inverted. Feeding one register's true output into the serial input of the next register chains several registers into a longer converter.

The shift clock is the logical OR of two pins. Either pin can be held low and then acts as the other one's active-low enable. Holding either pin high freezes the register. The model runs on a fast system clock. It treats both clock pins and the load line as levels that are already synchronized, and it finds shift edges by comparing each sample of the OR'd level with the previous one.

A small rule monitor watches two ordering rules. The enable pin may only rise while the clock pin is high. Load may only be released while at least one clock pin is high. Each broken rule sets its own sticky flag, and the flags stay set until a clear pulse.

Top module: `plso_shifter`

## Requirements
- R1: Reset (rstN low) clears every stage to 0 and both rule flags to 0, so serOut=0 and serOutN=1. The stored previous level of the combined clock, the enable pin and the load line resets to 1, so no edge is seen on the first sample after reset.
- R2: While loadN is low, stage i takes parIn[i] at every system clock edge, and it keeps following parIn if parIn changes. serOut shows parIn[WIDTH-1] one system clock after it is sampled.
- R3: While loadN is high, a 0-to-1 change of (shiftClk OR shiftGateN) between two consecutive samples shifts the register. Stage i takes stage i-1, stage 0 takes serIn, and serOut reflects the result one system clock later.
- R4: Without such a change the stages hold. In particular, while shiftGateN stays high, toggling shiftClk moves nothing, and while shiftClk stays high, toggling shiftGateN moves nothing.
- R5: A combined-clock rising edge that is sampled while loadN is low is ignored. The load value wins, and no shift happens later because of that edge.
- R6: serOutN is always the complement of serOut, including during load and reset.
- R7: A sample where shiftGateN goes 0 to 1 while shiftClk is 0 sets gateRiseErr one system clock later. The flag stays set until it is cleared.
- R8: A sample where loadN goes 0 to 1 while shiftClk and shiftGateN are both 0 sets loadRiseErr one system clock later. The flag stays set until it is cleared.
- R9: clrFlags high on a sample clears both flags on the next system clock. If a new violation is sampled in the same cycle as the clear, that flag is set instead.
- R10: When one register's serOut is wired to a second register's serIn and both share the clock, enable and load lines, each shift moves the first register's last stage into the second register's stage 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| loadN | input | 1 | Active-low parallel load level |
| parIn | input | WIDTH | Parallel word; bit i goes to stage i |
| serIn | input | 1 | Serial data into stage 0 |
| shiftClk | input | 1 | Shift clock pin, OR'd with shiftGateN |
| shiftGateN | input | 1 | Second clock pin, usually used as an active-low enable |
| clrFlags | input | 1 | Clears both rule flags |
| serOut | output | 1 | Last stage (index WIDTH-1) |
| serOutN | output | 1 | Complement of the last stage |
| gateRiseErr | output | 1 | Sticky flag: enable pin rose while the clock pin was low |
| loadRiseErr | output | 1 | Sticky flag: load released while both clock pins were low |

## Verification
Two collisions are provoked on purpose. The first is a combined-clock rising edge sampled while loadN is low. The bench toggles shiftClk during a long load and expects serOut to keep tracking parIn[WIDTH-1], with no shift showing after load is released with the clock already high. The second is a clear pulse sampled in the same cycle as a fresh enable-rise violation, where the flag is expected to remain set. Random sequences over loadN, both clock pins and clrFlags hit these overlaps again and again, and every cycle is compared with a bench model built from the requirements.

// File: rtl/plso_pkg.sv
package plso_pkg;
  // Strobes from the control to the stage datapath; at most one is high.
  typedef struct packed {
    logic load;
    logic shift;
  } stageCmd_t;
endpackage

// File: rtl/plso_ctrl.sv
module plso_ctrl
  import plso_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      loadN,
  input  logic      shiftClk,
  input  logic      shiftGateN,
  output stageCmd_t cmd
);
  logic combLevel;
  logic combPrev;
  logic combRise;

  assign combLevel = shiftClk | shiftGateN;
  assign combRise  = combLevel & ~combPrev;

  always_ff @(posedge clk) begin
    if (!rstN) combPrev <= 1'b1;
    else       combPrev <= combLevel;
  end

  always_comb begin
    cmd.load  = ~loadN;
    cmd.shift = loadN & combRise;
  end

  AST_GATE_HELD_NO_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (shiftGateN && $past(shiftGateN)) |-> !cmd.shift); // R4
  AST_CLK_HELD_NO_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (shiftClk && $past(shiftClk)) |-> !cmd.shift); // R4
endmodule

// File: rtl/plso_stages.sv
module plso_stages
  import plso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  stageCmd_t        cmd,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serIn,
  output logic             lastStage
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] stages;
  logic [WIDTH-1:0] stagesNext;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic feed;
    if (i == 0) begin : g_head
      assign feed = serIn;
    end else begin : g_body
      assign feed = stages[i-1];
    end
    assign stagesNext[i] = cmd.load  ? parIn[i] :
                           cmd.shift ? feed     : stages[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) stages <= '0;
    else       stages <= stagesNext;
  end

  assign lastStage = stages[LAST];

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> stages == $past(parIn)); // R2
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    cmd.shift |=> stages == {$past(stages[LAST-1:0]), $past(serIn)}); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && !cmd.shift) |=> $stable(stages)); // R4
  AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.load, cmd.shift})); // R5
endmodule

// File: rtl/plso_rule_mon.sv
module plso_rule_mon (
  input  logic clk,
  input  logic rstN,
  input  logic loadN,
  input  logic shiftClk,
  input  logic shiftGateN,
  input  logic clrFlags,
  output logic gateRiseErr,
  output logic loadRiseErr
);
  logic gatePrev;
  logic loadPrev;
  logic gateBad;
  logic loadBad;

  assign gateBad = shiftGateN & ~gatePrev & ~shiftClk;
  assign loadBad = loadN & ~loadPrev & ~shiftClk & ~shiftGateN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gatePrev    <= 1'b1;
      loadPrev    <= 1'b1;
      gateRiseErr <= 1'b0;
      loadRiseErr <= 1'b0;
    end else begin
      gatePrev    <= shiftGateN;
      loadPrev    <= loadN;
      gateRiseErr <= (gateRiseErr & ~clrFlags) | gateBad;
      loadRiseErr <= (loadRiseErr & ~clrFlags) | loadBad;
    end
  end

  AST_GATE_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (gateRiseErr && !clrFlags) |=> gateRiseErr); // R7
  AST_LOAD_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (loadRiseErr && !clrFlags) |=> loadRiseErr); // R8
  AST_GATE_LEGAL_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (clrFlags && shiftClk) |=> !gateRiseErr); // R9
endmodule

// File: rtl/plso_shifter.sv
module plso_shifter
  import plso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadN,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serIn,
  input  logic             shiftClk,
  input  logic             shiftGateN,
  input  logic             clrFlags,
  output logic             serOut,
  output logic             serOutN,
  output logic             gateRiseErr,
  output logic             loadRiseErr
);
  stageCmd_t cmd;
  logic      lastStage;

  plso_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .loadN      (loadN),
    .shiftClk   (shiftClk),
    .shiftGateN (shiftGateN),
    .cmd        (cmd)
  );

  plso_stages #(.WIDTH(WIDTH)) i_stages (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .parIn     (parIn),
    .serIn     (serIn),
    .lastStage (lastStage)
  );

  plso_rule_mon i_mon (
    .clk         (clk),
    .rstN        (rstN),
    .loadN       (loadN),
    .shiftClk    (shiftClk),
    .shiftGateN  (shiftGateN),
    .clrFlags    (clrFlags),
    .gateRiseErr (gateRiseErr),
    .loadRiseErr (loadRiseErr)
  );

  assign serOut  = lastStage;
  assign serOutN = ~lastStage;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    !loadN |=> serOut == $past(parIn[WIDTH-1])); // R5
endmodule

// File: tb/test_plso_shifter.sv
module test_plso_shifter;
  localparam int W = 8;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadN = 1'b1;
  logic [W-1:0] parA = '0;
  logic [W-1:0] parB = '0;
  logic serIn = 1'b0;
  logic cp = 1'b1;
  logic ce = 1'b1;
  logic clr = 1'b0;
  logic serOut, serOutN, gateErr, loadErr;
  logic tailOut, tailOutN, tailGateErr, tailLoadErr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [W-1:0] mA, mB;
  logic mPrevComb, mPrevGate, mPrevLd, mGateErr, mLdErr;

  always #(PERIOD/2) clk = ~clk;

  plso_shifter #(.WIDTH(W)) i_plso_shifter (
    .clk(clk), .rstN(rstN), .loadN(loadN), .parIn(parA), .serIn(serIn),
    .shiftClk(cp), .shiftGateN(ce), .clrFlags(clr),
    .serOut(serOut), .serOutN(serOutN),
    .gateRiseErr(gateErr), .loadRiseErr(loadErr)
  );

  // second register chained behind the first (R10)
  plso_shifter #(.WIDTH(W)) i_plso_shifter_tail (
    .clk(clk), .rstN(rstN), .loadN(loadN), .parIn(parB), .serIn(serOut),
    .shiftClk(cp), .shiftGateN(ce), .clrFlags(clr),
    .serOut(tailOut), .serOutN(tailOutN),
    .gateRiseErr(tailGateErr), .loadRiseErr(tailLoadErr)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  task automatic modelReset();
    mA = '0; mB = '0;
    mPrevComb = 1'b1; mPrevGate = 1'b1; mPrevLd = 1'b1;
    mGateErr = 1'b0; mLdErr = 1'b0;
  endtask

  task automatic step(input string tag);
    logic comb, rise;
    logic [W-1:0] nA, nB;
    logic nGate, nLd;
    comb = cp | ce;
    rise = comb & ~mPrevComb;
    if (!loadN) begin
      nA = parA; nB = parB;
    end else if (rise) begin
      nA = {mA[W-2:0], serIn};
      nB = {mB[W-2:0], mA[W-1]};
    end else begin
      nA = mA; nB = mB;
    end
    nGate = (mGateErr & ~clr) | (ce & ~mPrevGate & ~cp);
    nLd   = (mLdErr & ~clr) | (loadN & ~mPrevLd & ~cp & ~ce);
    @(posedge clk);
    #1;
    mA = nA; mB = nB; mGateErr = nGate; mLdErr = nLd;
    mPrevComb = comb; mPrevGate = ce; mPrevLd = loadN;
    check(tag, serOut, mA[W-1]);
    check("R6", serOutN, ~mA[W-1]);
    check("R7", gateErr, mGateErr);
    check("R8", loadErr, mLdErr);
    check("R10", tailOut, mB[W-1]);
  endtask

  task automatic pulseClear();
    clr = 1'b1; step("R9");
    clr = 1'b0; step("R9");
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'h5EED);
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", serOut, 1'b0);
    check("R1", serOutN, 1'b1);
    check("R1", gateErr, 1'b0);
    check("R1", loadErr, 1'b0);
    rstN = 1'b1;
    step("R1");

    // R2 load and follow
    loadN = 1'b0; parA = 8'hA5; parB = 8'h0F;
    step("R2");
    check("R2", serOut, 1'b1);
    parA = 8'h3C;
    step("R2");
    check("R2", serOut, 1'b0);
    // release load with clock high: legal
    ce = 1'b0; step("R8");
    loadN = 1'b1; step("R8");

    // R3 shifting via shiftClk with gate low
    for (int i = 0; i < W; i++) begin
      cp = 1'b0; serIn = i[0]; step("R3");
      cp = 1'b1; step("R3");
    end

    // R4 gate held high, clock toggles
    ce = 1'b1; step("R4");
    for (int i = 0; i < 4; i++) begin
      cp = 1'b0; step("R4");
      cp = 1'b1; step("R4");
    end
    // R4 clock held high, gate toggles
    for (int i = 0; i < 3; i++) begin
      ce = 1'b0; step("R4");
      ce = 1'b1; step("R4");
    end
    ce = 1'b0; step("R4");

    // R5 edges during load are ignored
    loadN = 1'b0; parA = 8'h81;
    for (int i = 0; i < 4; i++) begin
      cp = 1'b0; step("R5");
      cp = 1'b1; step("R5");
      check("R5", serOut, 1'b1);
    end
    loadN = 1'b1; step("R5");
    step("R5");
    check("R5", serOut, 1'b1);

    // R7 gate rises while clock low
    cp = 1'b0; step("R7");
    ce = 1'b1; step("R7");
    check("R7", gateErr, 1'b1);
    cp = 1'b1; step("R7");
    step("R7");
    check("R7", gateErr, 1'b1);
    pulseClear();
    check("R9", gateErr, 1'b0);

    // R9 clear collides with a new violation
    ce = 1'b0; step("R9");
    cp = 1'b0; step("R9");
    ce = 1'b1; clr = 1'b1; step("R9");
    check("R9", gateErr, 1'b1);
    clr = 1'b0; cp = 1'b1; step("R9");
    pulseClear();

    // R8 load released with both clock pins low
    ce = 1'b0; cp = 1'b0; loadN = 1'b0; step("R8");
    loadN = 1'b1; step("R8");
    check("R8", loadErr, 1'b1);
    cp = 1'b1; step("R8");
    pulseClear();
    check("R8", loadErr, 1'b0);

    // R10 cascade through two registers
    loadN = 1'b0; parA = 8'hC3; parB = 8'h5A; step("R10");
    loadN = 1'b1; serIn = 1'b0; step("R10");
    for (int i = 0; i < 2 * W; i++) begin
      cp = 1'b0; step("R10");
      cp = 1'b1; step("R10");
    end

    // random mix
    for (int i = 0; i < 1500; i++) begin
      loadN = (($urandom % 8) != 0);
      cp    = $urandom % 2;
      ce    = (($urandom % 3) == 0);
      serIn = $urandom % 2;
      clr   = (($urandom % 16) == 0);
      parA  = $urandom;
      parB  = $urandom;
      step("R3");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule